// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between an 8-bit processor that has a 16-bit logical address space and an SRAM larger than 64 KB. It makes each physical address from the logical address and a few bank registers. Logical addresses at the top of the map fall in a common window. That window always reaches the same physical memory, with the extended address bits held at zero. All other logical addresses are placed in a selectable bank, and the bank number becomes the extended physical address bits.

Software sets the mapping through three I/O ports: a read-bank register, a write-bank register and a configuration register. The configuration register holds a copy-enable bit and the size of the common window, which ranges from 4 KB to 32 KB in steps of 4 KB. When copy mode is on, memory reads come from the read bank and memory writes go to the write bank. A move loop can then copy data from one bank to another without passing it through common memory. The block also drives the SRAM chip enable. The default build has 4 bank bits (16 banks, 1 MB physical) and a 16 KB common window at reset.

Top module: `bank_mapper`

## Requirements
- R1: After reset the read bank is 0, the write bank is 0, copy mode is off and the common-size code is 3, which gives a 16 KB window.
- R2: A logical address in the top 4 KB (cpu_addr[15:12] = 4'hF) always gives phys_addr[19:16] = 0, whatever the bank and size settings are.
- R3: A memory read at a banked logical address gives phys_addr = {read bank, cpu_addr}.
- R4: With common-size code c, a logical address is in the common window when cpu_addr[15:12] >= 15 - c. The window is then (c+1)*4 KB, and its accesses give phys_addr = {4'h0, cpu_addr}.
- R5: An I/O write (io_req and wr_strb high, m1 low) to port cpu_addr[7:0] = 8'h40 loads cpu_wdata[3:0] into the read bank at that clock edge. The new bank applies from the following cycle.
- R6: An I/O write to port 8'h41 loads cpu_wdata[3:0] into the write bank.
- R7: An I/O write to port 8'h42 loads copy enable from cpu_wdata[0] and the size code from cpu_wdata[3:1]. While copy mode is on, banked memory writes use the write bank and banked memory reads still use the read bank.
- R8: While copy mode is off, banked memory writes use the read bank, and the value held in the write bank has no effect.
- R9: sram_ce is high only when mem_req is high, io_req is low, and rd_strb or wr_strb is high. It is never high on I/O or interrupt-acknowledge cycles.
- R10: Interrupt-acknowledge cycles (io_req and m1 high) and I/O reads never change any register, even when they carry a mapper port number.
- R11: The low 16 bits of phys_addr always equal cpu_addr.
- R12: I/O writes to port numbers other than 8'h40 to 8'h42 leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical address; bits 7:0 give the port number on I/O cycles |
| cpu_wdata | input | 8 | CPU write data, used by I/O register writes |
| mem_req | input | 1 | Memory cycle in progress |
| io_req | input | 1 | I/O cycle in progress |
| rd_strb | input | 1 | Read strobe |
| wr_strb | input | 1 | Write strobe |
| m1 | input | 1 | Opcode fetch; together with io_req it marks interrupt acknowledge |
| phys_addr | output | 20 | Physical SRAM address |
| sram_ce | output | 1 | SRAM chip enable |

## Verification
The bench checks each common-window size right at its boundary, at the last banked address and the first common one. A size decoder that is off by one page would put one of these two addresses on the wrong side. It runs copy mode with the read and write banks set differently. A design that swapped the two banks, or sent reads to the write bank, would then show the wrong extended bits on one of the two directions. Interrupt-acknowledge cycles, I/O reads and writes to unused ports are all sent with mapper port numbers or live data, and the bench then reads a mapped address to catch any register that changed. Refresh-style cycles (mem_req with no strobe) are checked to confirm that they do not enable the SRAM.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  // Logical space is 16 bits; the common window is counted in 4 KB pages.
  localparam int unsigned LOG_W   = 16;
  localparam int unsigned PAGE_W  = 4;
  localparam int unsigned SIZE_W  = 3;

  typedef struct packed {
    logic              copy_en;
    logic [SIZE_W-1:0] size_code;
  } map_cfg_t;
endpackage

// File: rtl/bm_regs.sv
module bm_regs
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_W    = 4,
  parameter logic [7:0]  PORT_RBANK = 8'h40,
  parameter logic [7:0]  PORT_WBANK = 8'h41,
  parameter logic [7:0]  PORT_CFG   = 8'h42,
  parameter logic [SIZE_W-1:0] SIZE_RST = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req,
  input  logic              wr_strb,
  input  logic              m1,
  input  logic [7:0]        port,
  input  logic [7:0]        wdata,
  output logic [BANK_W-1:0] rd_bank,
  output logic [BANK_W-1:0] wr_bank,
  output map_cfg_t          cfg
);
  logic io_wr;
  logic unused_hi;

  assign io_wr     = io_req & wr_strb & ~m1;
  assign unused_hi = ^wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank       <= '0;
      wr_bank       <= '0;
      cfg.copy_en   <= 1'b0;
      cfg.size_code <= SIZE_RST;
    end else if (io_wr) begin
      if (port == PORT_RBANK) rd_bank <= wdata[BANK_W-1:0];
      if (port == PORT_WBANK) wr_bank <= wdata[BANK_W-1:0];
      if (port == PORT_CFG) begin
        cfg.copy_en   <= wdata[0];
        cfg.size_code <= wdata[SIZE_W:1];
      end
    end
  end
endmodule

// File: rtl/bm_window.sv
module bm_window
  import bank_mapper_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [SIZE_W-1:0] size_code,
  output logic              in_common
);
  logic [PAGE_W-1:0] first_page;

  // Window of (code+1) pages ending at the top of the map.
  assign first_page = PAGE_W'(4'hF) - PAGE_W'(size_code);
  assign in_common  = (page >= first_page);
endmodule

// File: rtl/bm_xlate.sv
module bm_xlate
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_W = 4
) (
  input  logic [LOG_W-1:0]        addr,
  input  logic                    in_common,
  input  logic                    mem_wr,
  input  logic                    copy_en,
  input  logic [BANK_W-1:0]       rd_bank,
  input  logic [BANK_W-1:0]       wr_bank,
  output logic [LOG_W+BANK_W-1:0] phys
);
  logic [BANK_W-1:0] sel_bank;

  assign sel_bank        = (copy_en && mem_wr) ? wr_bank : rd_bank;
  assign phys[LOG_W-1:0] = addr;

  // Each extended line is its bank bit gated off inside the common window.
  for (genvar i = 0; i < BANK_W; i++) begin : g_ext
    assign phys[LOG_W+i] = sel_bank[i] & ~in_common;
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BANK_W     = 4,
  parameter logic [7:0]  PORT_RBANK = 8'h40,
  parameter logic [7:0]  PORT_WBANK = 8'h41,
  parameter logic [7:0]  PORT_CFG   = 8'h42,
  parameter logic [2:0]  SIZE_RST   = 3'd3,
  localparam int unsigned PHYS_W    = 16 + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              rd_strb,
  input  logic              wr_strb,
  input  logic              m1,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              sram_ce
);
  logic [BANK_W-1:0] rd_bank;
  logic [BANK_W-1:0] wr_bank;
  map_cfg_t          cfg;
  logic              in_common;
  logic              copy_en;
  logic              mem_wr;

  assign copy_en = cfg.copy_en;
  assign mem_wr  = mem_req & wr_strb;

  bm_regs #(
    .BANK_W(BANK_W), .PORT_RBANK(PORT_RBANK), .PORT_WBANK(PORT_WBANK),
    .PORT_CFG(PORT_CFG), .SIZE_RST(SIZE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .wr_strb(wr_strb), .m1(m1),
    .port(cpu_addr[7:0]), .wdata(cpu_wdata),
    .rd_bank(rd_bank), .wr_bank(wr_bank), .cfg(cfg)
  );

  bm_window u_window (
    .page(cpu_addr[15:12]), .size_code(cfg.size_code), .in_common(in_common)
  );

  bm_xlate #(.BANK_W(BANK_W)) u_xlate (
    .addr(cpu_addr), .in_common(in_common), .mem_wr(mem_wr),
    .copy_en(copy_en), .rd_bank(rd_bank), .wr_bank(wr_bank), .phys(phys_addr)
  );

  assign sram_ce = mem_req & ~io_req & (rd_strb | wr_strb);
endmodule

// File: rtl/bank_mapper_sva.sv
module bank_mapper_sva #(
  parameter int unsigned BANK_W = 4,
  localparam int unsigned PHYS_W = 16 + BANK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              mem_req,
  input logic              io_req,
  input logic              rd_strb,
  input logic              wr_strb,
  input logic              m1,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              sram_ce,
  input logic              copy_en,
  input logic              in_common,
  input logic [BANK_W-1:0] rd_bank,
  input logic [BANK_W-1:0] wr_bank
);
  a_r1_reset_values: assert property (@(posedge clk)
    !rst_n |=> (rd_bank == '0 && wr_bank == '0 && !copy_en));

  a_r2_top_page_common: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_ce && cpu_addr[15:12] == 4'hF) |-> (phys_addr[PHYS_W-1:16] == '0));

  a_r7_read_uses_read_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rd_strb && !wr_strb && !in_common) |-> (phys_addr[PHYS_W-1:16] == rd_bank));

  a_r8_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && wr_strb && !copy_en && !in_common) |-> (phys_addr[PHYS_W-1:16] == rd_bank));

  a_r10_intack_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && m1) |=> ($stable(rd_bank) && $stable(wr_bank) && $stable(copy_en)));

  a_r12_hold_without_io_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && wr_strb) |=> ($stable(rd_bank) && $stable(wr_bank)));
endmodule

bind bank_mapper bank_mapper_sva #(.BANK_W(BANK_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
  .io_req(io_req), .rd_strb(rd_strb), .wr_strb(wr_strb), .m1(m1),
  .phys_addr(phys_addr), .sram_ce(sram_ce), .copy_en(copy_en),
  .in_common(in_common), .rd_bank(rd_bank), .wr_bank(wr_bank)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        mem_req = 1'b0, io_req = 1'b0, rd_strb = 1'b0, wr_strb = 1'b0, m1 = 1'b0;
  logic [19:0] phys_addr;
  logic        sram_ce;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .mem_req(mem_req), .io_req(io_req), .rd_strb(rd_strb), .wr_strb(wr_strb),
    .m1(m1), .phys_addr(phys_addr), .sram_ce(sram_ce)
  );

  typedef struct packed {
    logic [3:0]  rb;
    logic [3:0]  wb;
    logic [7:0]  cfg;
    logic [15:0] addr;
    logic        wr;
    logic [19:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd1,  4'd0, 8'h06, 16'h1234, 1'b0, 20'h11234},  // R3
    '{4'd1,  4'd0, 8'h06, 16'hC000, 1'b0, 20'h0C000},  // R4 16 KB window
    '{4'd1,  4'd0, 8'h06, 16'hBFFF, 1'b0, 20'h1BFFF},  // R4 last banked
    '{4'd2,  4'd5, 8'h07, 16'h2000, 1'b1, 20'h52000},  // R7 copy write
    '{4'd2,  4'd5, 8'h07, 16'h2000, 1'b0, 20'h22000},  // R7 copy read
    '{4'd2,  4'd5, 8'h06, 16'h2000, 1'b1, 20'h22000},  // R8 copy off
    '{4'd3,  4'd0, 8'h00, 16'hE000, 1'b0, 20'h3E000},  // R4 4 KB window
    '{4'd3,  4'd0, 8'h00, 16'hF000, 1'b0, 20'h0F000},  // R2
    '{4'd7,  4'd0, 8'h0E, 16'h8000, 1'b0, 20'h08000},  // R4 32 KB window
    '{4'd7,  4'd0, 8'h0E, 16'h7FFF, 1'b0, 20'h77FFF},  // R4
    '{4'd15, 4'd9, 8'h0F, 16'h0000, 1'b1, 20'h90000},  // R6 R7
    '{4'd15, 4'd9, 8'h0F, 16'hFFFF, 1'b1, 20'h0FFFF}   // R2 R11
  };

  function automatic logic [19:0] ref_phys(input logic [15:0] a, input logic [3:0] rb,
      input logic [3:0] wb, input logic [2:0] code, input logic cp, input logic w);
    if (a[15:12] >= 4'd15 - {1'b0, code}) return {4'h0, a};
    return {((w && cp) ? wb : rb), a};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    mem_req = 0; io_req = 0; rd_strb = 0; wr_strb = 0; m1 = 0;
  endtask

  task automatic io_cycle(input logic [7:0] port, input logic [7:0] d,
                          input logic w, input logic ack);
    @(negedge clk);
    cpu_addr = {8'h00, port}; cpu_wdata = d;
    io_req = 1; wr_strb = w; rd_strb = ~w; m1 = ack;
    @(negedge clk);
    idle();
  endtask

  task automatic setup(input logic [3:0] rb, input logic [3:0] wb, input logic [7:0] cfg);
    io_cycle(8'h40, {4'h0, rb}, 1'b1, 1'b0);
    io_cycle(8'h41, {4'h0, wb}, 1'b1, 1'b0);
    io_cycle(8'h42, cfg, 1'b1, 1'b0);
  endtask

  task automatic mem(input logic [15:0] a, input logic w, input string tag,
                     input logic [19:0] exp);
    @(negedge clk);
    cpu_addr = a; mem_req = 1; wr_strb = w; rd_strb = ~w;
    #1;
    check(tag, {12'h0, phys_addr}, {12'h0, exp});
    check("R9 ce on memory cycle", {31'h0, sram_ce}, 32'h1);
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9 ce idle in reset", {31'h0, sram_ce}, 32'h0);
    rst_n = 1;
    // R1: bank 0, copy off, 16 KB window
    mem(16'h4000, 1'b0, "R1 reset read bank", 20'h04000);
    io_cycle(8'h41, 8'h04, 1'b1, 1'b0);
    mem(16'h1000, 1'b1, "R1 reset copy off", 20'h01000);
    io_cycle(8'h40, 8'h01, 1'b1, 1'b0);
    mem(16'hBFFF, 1'b0, "R1 reset size code", 20'h1BFFF);
    mem(16'hC000, 1'b0, "R1 reset size code", 20'h0C000);

    for (int i = 0; i < 12; i++) begin
      setup(VECS[i].rb, VECS[i].wb, VECS[i].cfg);
      mem(VECS[i].addr, VECS[i].wr, "R3 R7 vector", VECS[i].exp);
    end

    // Sweep every size, bank and copy direction (R4 R7 R8)
    for (int code = 0; code < 8; code++)
      for (int b = 0; b < 16; b++)
        for (int cp = 0; cp < 2; cp++) begin
          logic [15:0] edge_a;
          edge_a = 16'((15 - code) << 12);
          setup(4'(b), 4'(15 - b), {4'h0, 3'(code), 1'(cp)});
          mem(edge_a - 16'd1, 1'b1, "R7 R8 sweep write",
              ref_phys(edge_a - 16'd1, 4'(b), 4'(15 - b), 3'(code), 1'(cp), 1'b1));
          mem(edge_a - 16'd1, 1'b0, "R3 sweep read",
              ref_phys(edge_a - 16'd1, 4'(b), 4'(15 - b), 3'(code), 1'(cp), 1'b0));
          mem(edge_a, 1'b0, "R4 sweep boundary", {4'h0, edge_a});
        end

    // R9: no enable on I/O, interrupt acknowledge or refresh-style cycles
    setup(4'd6, 4'd2, 8'h06);
    @(negedge clk);
    cpu_addr = 16'h0040; io_req = 1; rd_strb = 1; #1;
    check("R9 no ce on io", {31'h0, sram_ce}, 32'h0);
    m1 = 1; rd_strb = 0; #1;
    check("R9 no ce on int ack", {31'h0, sram_ce}, 32'h0);
    @(negedge clk); idle();
    cpu_addr = 16'h1000; mem_req = 1; #1;
    check("R9 no ce without strobe", {31'h0, sram_ce}, 32'h0);
    @(negedge clk); idle();

    // R10: interrupt acknowledge and I/O read never load registers
    io_cycle(8'h40, 8'h0A, 1'b1, 1'b1);
    io_cycle(8'h42, 8'h01, 1'b1, 1'b1);
    io_cycle(8'h40, 8'h0B, 1'b0, 1'b0);
    mem(16'h3000, 1'b0, "R10 read bank kept", 20'h63000);
    mem(16'h3000, 1'b1, "R10 copy still off", 20'h63000);
    // R12: other port numbers ignored
    io_cycle(8'h43, 8'h0C, 1'b1, 1'b0);
    io_cycle(8'h3F, 8'h0D, 1'b1, 1'b0);
    mem(16'h3000, 1'b0, "R12 other port ignored", 20'h63000);
    // R5 R6: new bank usable in the very next cycle
    io_cycle(8'h40, 8'h0E, 1'b1, 1'b0);
    mem(16'h0123, 1'b0, "R5 read bank load", 20'hE0123);
    io_cycle(8'h42, 8'h07, 1'b1, 1'b0);
    mem(16'h0123, 1'b1, "R6 write bank load", 20'h20123);

    // R1 again after a mid-run reset
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    mem(16'h0123, 1'b1, "R1 reset after use", 20'h00123);
    mem(16'hBFFF, 1'b0, "R1 reset after use", 20'h0BFFF);

    finish_run();
  end
endmodule